// File: doc/BRIEF.md
# Flash Command Security Gate

This block sits in front of a flash controller and rules on every command before it runs. It holds four sticky protection bits. For each command it weighs the command type, the target address and whether the request came from an external programmer or from code running on the chip itself. One cycle after the request it returns either a grant pulse or a deny pulse. The flash array, its timing and the command transport are outside this block.

The security-set command raises protection bits in a pending copy. That copy becomes the active copy only when a programming-mode entry pulse arrives, and only the active copy governs decisions. A granted chip erase wipes every protection bit. Once the chip-erase protection is active, nothing can lower any bit again. Both copies can be read on output ports.

Top module: `flash_sec_gate`

## Requirements
- R1: After reset both `lock_o` and `pend_o` are 4'b0000, and `grant_o` and `deny_o` are low. With all bits clear, every command from either source is granted.
- R2: When `req_i` is high at a rising edge, exactly one of `grant_o` and `deny_o` is high during the following cycle, and only for that cycle. Neither output is high in a cycle that does not follow a request.
- R3: Command codes on `cmd_i` are 0 for chip erase, 1 for block erase, 2 for write and 3 for security-set. A security-set is always granted. It ORs `bits_i` into `pend_o`, and the new value is visible in the cycle after the request. A zero in `bits_i` never lowers a pending bit, and `lock_o` does not change.
- R4: On a `prog_entry_i` pulse, `lock_o` takes the value of `pend_o`. Bits that are pending but not yet active have no effect on decisions.
- R5: A granted chip erase clears both `lock_o` and `pend_o` on the edge that produces its grant.
- R6: Bit 0 of `lock_o` is the chip-erase lock. While it is set, a chip erase from the external programmer (`ext_i`=1) is denied. No command clears any bit while it is set. A self-programmed chip erase is granted but leaves every bit unchanged. Security-set can still add bits.
- R7: Bit 1 is the block-erase lock. It denies block erase from the external programmer only. Self-programmed block erase is granted.
- R8: Bit 2 is the write lock. It denies both write and block erase from the external programmer. Self-programmed write and block erase are granted.
- R9: Bit 3 is the boot lock. It denies write and block erase from either source when `addr_i` is below 0x01000. It denies every chip erase, because a chip erase covers the boot area, and in that case no bits are cleared. Addresses from 0x01000 upward are unaffected by this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Command request strobe |
| cmd_i | input | 2 | Command code |
| addr_i | input | ADDR_W | Target address |
| ext_i | input | 1 | 1 = external programmer, 0 = self-programming |
| bits_i | input | 4 | Bits to add on security-set |
| prog_entry_i | input | 1 | Programming-mode entry pulse |
| grant_o | output | 1 | Command permitted (one-cycle pulse) |
| deny_o | output | 1 | Command refused (one-cycle pulse) |
| lock_o | output | 4 | Active protection bits |
| pend_o | output | 4 | Pending protection bits |

## Verification
The bench targets the address boundary at 0x00FFF/0x01000 under the boot lock. A design with an off-by-one comparison would either deny the first unprotected address or grant the last protected one. It exercises the difference between sources: a gate that ignored the source would refuse self-programmed writes, and one that forgot the write lock also covers block erase would let an external block erase through. It probes the moment pending bits become active, which catches a gate that applies a security-set at once. It also checks that a security-set with zero bits cannot lower protection and that a chip erase under the chip-erase lock leaves every bit in place, which catches a design that clears locks it must keep.

// File: rtl/flash_sec_gate.sv
module flash_sec_gate #(
  parameter int ADDR_W   = 20,
  parameter int BOOT_TOP = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ext_i,
  input  logic [3:0]        bits_i,
  input  logic              prog_entry_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [3:0]        lock_o,
  output logic [3:0]        pend_o
);
  localparam logic [1:0] CMD_CHIP = 2'd0;
  localparam logic [1:0] CMD_BLK  = 2'd1;
  localparam logic [1:0] CMD_WR   = 2'd2;
  localparam logic [1:0] CMD_SET  = 2'd3;
  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_TOP);

  logic [3:0] act_q, pend_q;
  logic       refuse, boot_hit, wipe;

  assign boot_hit = addr_i < BOOT_LIM;

  always_comb begin
    unique case (cmd_i)
      CMD_CHIP: refuse = (ext_i && act_q[0]) || act_q[3];
      CMD_BLK:  refuse = (ext_i && (act_q[1] || act_q[2])) || (act_q[3] && boot_hit);
      CMD_WR:   refuse = (ext_i && act_q[2]) || (act_q[3] && boot_hit);
      default:  refuse = 1'b0;
    endcase
  end

  assign wipe = req_i && cmd_i == CMD_CHIP && !refuse && !act_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
      act_q   <= '0;
      pend_q  <= '0;
    end else begin
      grant_o <= req_i && !refuse;
      deny_o  <= req_i && refuse;
      if (wipe) begin
        act_q  <= '0;
        pend_q <= '0;
      end else begin
        if (prog_entry_i) act_q <= pend_q;
        if (req_i && cmd_i == CMD_SET) pend_q <= pend_q | bits_i;
      end
    end
  end

  assign lock_o = act_q;
  assign pend_o = pend_q;

  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_i) |-> (grant_o ^ deny_o));
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_i) |-> !(grant_o || deny_o));
  // R6
  perm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_q[0]) |-> ((act_q & $past(act_q)) == $past(act_q)));
  // R3
  set_only_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_i && cmd_i == CMD_SET) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R4
  active_in_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q & ~pend_q) == 4'b0000);
  // R9
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_i && act_q[3] && cmd_i != CMD_SET && (cmd_i == CMD_CHIP || boot_hit)) |-> deny_o);
endmodule

// File: tb/flash_sec_gate_tb.sv
module flash_sec_gate_tb_top;
  logic clk = 0, rst_n = 0, req = 0, ext = 0, pe = 0;
  logic [1:0] cmd = 0;
  logic [19:0] addr = 0;
  logic [3:0] bits = 0;
  logic grant, deny;
  logic [3:0] lock, pend;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_sec_gate dut_i (.clk(clk), .rst_n(rst_n), .req_i(req), .cmd_i(cmd), .addr_i(addr),
    .ext_i(ext), .bits_i(bits), .prog_entry_i(pe), .grant_o(grant), .deny_o(deny),
    .lock_o(lock), .pend_o(pend));

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req = 0; pe = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(string tag, logic [1:0] c, logic [19:0] a, logic e, logic [3:0] b, logic g);
    @(negedge clk);
    req = 1; cmd = c; addr = a; ext = e; bits = b;
    @(negedge clk);
    req = 0;
    chk(tag, {2'b00, grant, deny}, {2'b00, g, !g});
    @(negedge clk);
    chk({tag, " R2 pulse ends"}, {2'b00, grant, deny}, 4'b0000);
  endtask

  task automatic enter_prog();
    @(negedge clk); pe = 1;
    @(negedge clk); pe = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lock", lock, 4'b0000);
    chk("R1 pend", pend, 4'b0000);
    chk("R1 outputs", {2'b00, grant, deny}, 4'b0000);
    repeat (3) @(negedge clk);
    chk("R2 idle", {2'b00, grant, deny}, 4'b0000);
  endtask

  task automatic t_open();
    issue("R1 self write", 2, 20'h00100, 0, 0, 1);
    issue("R1 ext write", 2, 20'h00100, 1, 0, 1);
    issue("R1 ext block erase boot", 1, 20'h00010, 1, 0, 1);
    issue("R1 ext chip erase", 0, 0, 1, 0, 1);
  endtask

  task automatic t_set_and_entry();
    issue("R3 set grant", 3, 0, 1, 4'b0110, 1);
    chk("R3 pend", pend, 4'b0110);
    chk("R3 lock unchanged", lock, 4'b0000);
    issue("R4 pending inert", 1, 20'h02000, 1, 0, 1);
    enter_prog();
    chk("R4 lock copied", lock, 4'b0110);
    issue("R7 ext block erase", 1, 20'h02000, 1, 0, 0);
    issue("R7 self block erase", 1, 20'h02000, 0, 0, 1);
    issue("R8 ext write", 2, 20'h02000, 1, 0, 0);
    issue("R8 self write", 2, 20'h02000, 0, 0, 1);
    issue("R3 zero set", 3, 0, 1, 4'b0000, 1);
    chk("R3 no lowering", pend, 4'b0110);
    issue("R5 chip erase", 0, 0, 1, 0, 1);
    chk("R5 lock cleared", lock, 4'b0000);
    chk("R5 pend cleared", pend, 4'b0000);
  endtask

  task automatic t_write_only();
    do_reset();
    issue("R8 set", 3, 0, 0, 4'b0100, 1);
    enter_prog();
    issue("R8 ext block erase", 1, 20'h03000, 1, 0, 0);
    issue("R8 self block erase", 1, 20'h03000, 0, 0, 1);
    issue("R7 ext write unaffected by bit1", 2, 20'h03000, 1, 0, 0);
  endtask

  task automatic t_boot();
    do_reset();
    issue("R9 set", 3, 0, 1, 4'b1000, 1);
    enter_prog();
    issue("R9 self write 0xFFF", 2, 20'h00FFF, 0, 0, 0);
    issue("R9 self write 0x1000", 2, 20'h01000, 0, 0, 1);
    issue("R9 ext block erase boot", 1, 20'h00010, 1, 0, 0);
    issue("R9 ext block erase high", 1, 20'h01000, 1, 0, 1);
    issue("R9 self chip erase", 0, 20'h05000, 0, 0, 0);
    chk("R9 lock kept", lock, 4'b1000);
  endtask

  task automatic t_perm();
    do_reset();
    issue("R6 set", 3, 0, 1, 4'b0001, 1);
    enter_prog();
    issue("R6 ext chip erase", 0, 0, 1, 0, 0);
    issue("R6 self chip erase", 0, 0, 0, 0, 1);
    chk("R6 lock kept", lock, 4'b0001);
    issue("R6 add bit", 3, 0, 1, 4'b0100, 1);
    enter_prog();
    chk("R6 lock grows", lock, 4'b0101);
    issue("R6 self chip erase again", 0, 0, 0, 0, 1);
    chk("R6 pend kept", pend, 4'b0101);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_open(); t_set_and_entry(); t_write_only(); t_boot(); t_perm();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule